// File: doc/BRIEF.md
# Bulk OUT Endpoint Receive Controller

This block sits behind the packet engine of a USB device and owns the receive side of one bulk OUT endpoint. The packet engine reports an OUT token, the data bytes of the packet that follows, and the end of that packet. The block stores the bytes in a 128-byte buffer. It answers each packet with an ACK, NAK or STALL handshake code for the engine to send on the bus.

Software sees one 32-bit control/status word and a byte pop port. The word holds two kinds of flags. Some describe the oldest unread packet: whether it is short, whether bytes are waiting, and whether a whole packet is available. Others control the endpoint: a forced stall and a DMA mode. Two sticky flags, stall-sent and packet-complete, are cleared by writing 1. A level interrupt output tells software or a DMA engine that received data is ready. Its timing depends on the DMA mode.

A per-packet length queue keeps packet boundaries. When the last byte of a packet is popped, the flags move on to the next packet. Only bytes of acknowledged packets can be read. A packet that is refused or stalled leaves the buffer untouched.

Top module: `usb_bulk_out_rx`

## Requirements
- R1: After reset the status word reads 0, `irq` is 0 and `hs_valid` is 0.
- R2: An OUT token is accepted when force-stall is 0, at least 64 bytes of the buffer are free and the length queue (4 slots) is not full. A following packet of 1 to 64 bytes is then answered with ACK (`hs_code` 2'b01) in the cycle after `rx_eop`. In that same cycle bit 1 (packet complete) becomes 1. The bytes come out of `fifo_rdata` in arrival order. `hs_valid` is a single-cycle pulse.
- R3: Bit 6 (not empty) is 1 exactly when acknowledged bytes remain unread. Bit 0 (service) is 1 exactly when at least one acknowledged packet is not fully read.
- R4: Bit 7 (short packet) is 1 when the oldest unread packet holds fewer than 64 bytes, and 0 when it holds 64 bytes or when no packet is queued.
- R5: With bit 5 (force stall) set, an OUT token is answered with STALL (2'b11) in the next cycle. The bytes of that packet are not stored, and no handshake follows its `rx_eop`.
- R6: Bit 4 (stall sent) becomes 1 together with each STALL handshake. Bits 4 and 1 are cleared only by writing 1 to them. A hardware set in the same cycle as such a write leaves the bit at 1.
- R7: `irq` equals bit 1 when bit 3 (DMA mode) is 0. When bit 3 is 1, `irq` equals bit 1 AND (fewer than 32 unread bytes).
- R8: A packet is answered with NAK (2'b10) after its `rx_eop`, and nothing of it is stored, in either of two cases. The first is a token arriving while fewer than 64 bytes are free or the length queue is full. The second is a packet longer than 64 bytes.
- R9: Bits 31:8 and bit 2 read 0 and ignore writes. Bits 5 and 3 read back the last value written.
- R10: Popping the last byte of a packet moves bits 7 and 0 to the next queued packet. A pop while no byte is readable changes nothing.
- R11: A zero-byte packet on an accepted token is answered with ACK and sets bit 1. It queues nothing.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_out | input | 1 | One-cycle strobe: OUT token addressed to this endpoint |
| rx_valid | input | 1 | One data byte of the current packet is on `rx_byte` |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | One-cycle strobe: current packet ended (no byte in this cycle) |
| hs_valid | output | 1 | Handshake code is valid this cycle |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current status word |
| fifo_rd | input | 1 | Pop one byte |
| fifo_rdata | output | 8 | Oldest unread byte |
| irq | output | 1 | Data-received interrupt (level) |

## Verification
Most internal faults in this block show up at the ports within a cycle or two. A wrong fill count or a lost commit shows first in bit 6, bit 0 and `irq`, in the cycle after the handshake. A wrong free-space decision turns an expected ACK into a NAK at the next token. A wrong length queue entry shows when a packet's last byte is popped: bit 7 or bit 0 moves one pop early or late. Byte order faults show on `fifo_rdata` at the first misplaced pop. Sticky-flag faults show when a clear write falls in the same cycle as a set.

// File: rtl/usb_oep_pkg.sv
// Shared types and register bit positions for the bulk OUT endpoint.
package usb_oep_pkg;
    localparam int REG_W = 32;

    // Bit positions of the status word (software decodes them)
    localparam int B_SHORT = 7;
    localparam int B_NEMPTY = 6;
    localparam int B_FSTALL = 5;
    localparam int B_SSTALL = 4;
    localparam int B_DMA = 3;
    localparam int B_PDONE = 1;
    localparam int B_SVC = 0;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_RECV,
        RX_DROP_NAK,
        RX_DROP_QUIET
    } rx_state_t;
endpackage

// File: rtl/oep_byte_fifo.sv
// Byte buffer with a speculative write pointer.
// Bytes become readable only after commit; abort rewinds the write side.
// Assumes DEPTH is a power of two and that commit and wr_en never coincide.
module oep_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          commit,
    input  logic          abort,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [AW:0]   level,
    output logic [AW:0]   free
);
    localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, cm_ptr, rd_ptr;
    logic [AW:0]  used;

    // Storage write, no reset needed for data
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Pointer update: speculative write, commit point, read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (abort) wr_ptr <= cm_ptr;
            else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (commit) cm_ptr <= wr_ptr;
            if (rd_en && level != '0) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Derived levels and head byte
    always_comb begin
        level   = cm_ptr - rd_ptr;
        used    = wr_ptr - rd_ptr;
        free    = DEPTH_V - used;
        rd_data = mem[rd_ptr[AW-1:0]];
    end
endmodule

// File: rtl/oep_len_queue.sv
// Small FIFO of packet lengths, one entry per stored packet.
// Assumes ENTRIES is a power of two; push when full and pop when empty are ignored.
module oep_len_queue #(
    parameter int ENTRIES = 4,
    parameter int LW = 7,
    localparam int QAW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [LW-1:0] push_len,
    input  logic          pop,
    output logic [LW-1:0] head_len,
    output logic          nonempty,
    output logic          full
);
    localparam logic [QAW:0] ENT_V = ENTRIES[QAW:0];

    logic [LW-1:0] slot [ENTRIES];
    logic [QAW:0]  wp, rp, cnt;

    // Slot write on push
    always_ff @(posedge clk) begin
        if (push && !full) slot[wp[QAW-1:0]] <= push_len;
    end

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && nonempty) rp <= rp + 1'b1;
        end
    end

    // Occupancy and head entry
    always_comb begin
        cnt      = wp - rp;
        nonempty = cnt != '0;
        full     = cnt == ENT_V;
        head_len = slot[rp[QAW-1:0]];
    end
endmodule

// File: rtl/oep_csr.sv
// Control/status word: read/write controls, write-1-to-clear sticky flags,
// read-only status assembled from the buffer state. A hardware set wins
// over a same-cycle clear.
module oep_csr
    import usb_oep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             set_sstall,
    input  logic             set_pdone,
    input  logic             st_short,
    input  logic             st_nempty,
    input  logic             st_svc,
    output logic             fstall,
    output logic             dma_mode,
    output logic             pdone,
    output logic [REG_W-1:0] reg_rdata
);
    logic sstall;

    // Control bits and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstall   <= 1'b0;
            dma_mode <= 1'b0;
            sstall   <= 1'b0;
            pdone    <= 1'b0;
        end else begin
            if (reg_wr) begin
                fstall   <= reg_wdata[B_FSTALL];
                dma_mode <= reg_wdata[B_DMA];
            end
            if (set_sstall) sstall <= 1'b1;
            else if (reg_wr && reg_wdata[B_SSTALL]) sstall <= 1'b0;
            if (set_pdone) pdone <= 1'b1;
            else if (reg_wr && reg_wdata[B_PDONE]) pdone <= 1'b0;
        end
    end

    // Read word assembly; unused bits stay zero
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[B_SHORT]  = st_short;
        reg_rdata[B_NEMPTY] = st_nempty;
        reg_rdata[B_FSTALL] = fstall;
        reg_rdata[B_SSTALL] = sstall;
        reg_rdata[B_DMA]    = dma_mode;
        reg_rdata[B_PDONE]  = pdone;
        reg_rdata[B_SVC]    = st_svc;
    end
endmodule

// File: rtl/usb_bulk_out_rx.sv
// Receive controller for one bulk OUT endpoint.
// Assumes the packet engine gives at most one of tok_out/rx_valid/rx_eop per
// cycle and that a token is followed by bytes and one rx_eop. Tokens during
// a packet are ignored. Handshake codes appear one cycle after the deciding strobe.
module usb_bulk_out_rx
    import usb_oep_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int MAX_PKT = 64,
    parameter int DMA_LOW_MARK = 32,
    parameter int LEN_SLOTS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tok_out,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eop,
    output logic        hs_valid,
    output logic [1:0]  hs_code,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        fifo_rd,
    output logic [7:0]  fifo_rdata,
    output logic        irq
);
    localparam int FAW = $clog2(FIFO_DEPTH);
    localparam int CW = $clog2(MAX_PKT) + 1;
    localparam logic [FAW:0] PKT_F = MAX_PKT[FAW:0];
    localparam logic [FAW:0] LOW_F = DMA_LOW_MARK[FAW:0];
    localparam logic [CW-1:0] PKT_C = MAX_PKT[CW-1:0];

    rx_state_t   st, st_nxt;
    hs_t         hs_nxt;
    logic [CW-1:0] cnt, rd_cnt;
    logic        over, over_nxt;
    logic        f_wr, f_commit, f_abort, q_push, set_sstall, set_pdone;
    logic [FAW:0] level, free;
    logic [CW-1:0] head_len;
    logic        q_nonempty, q_full, q_pop, pop_ok;
    logic        fstall, dma_mode, pdone;
    logic        rx_idle;

    assign rx_idle = (st == RX_IDLE);

    oep_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(f_wr), .wr_data(rx_byte),
        .commit(f_commit), .abort(f_abort),
        .rd_en(fifo_rd), .rd_data(fifo_rdata),
        .level(level), .free(free)
    );

    oep_len_queue #(.ENTRIES(LEN_SLOTS), .LW(CW)) i_lenq (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_len(cnt),
        .pop(q_pop), .head_len(head_len),
        .nonempty(q_nonempty), .full(q_full)
    );

    oep_csr i_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .set_sstall(set_sstall), .set_pdone(set_pdone),
        .st_short(q_nonempty && (head_len < PKT_C)),
        .st_nempty(level != '0),
        .st_svc(q_nonempty),
        .fstall(fstall), .dma_mode(dma_mode), .pdone(pdone),
        .reg_rdata(reg_rdata)
    );

    // Packet-side decisions for this cycle
    always_comb begin
        st_nxt     = st;
        hs_nxt     = HS_NONE;
        over_nxt   = over;
        f_wr       = 1'b0;
        f_commit   = 1'b0;
        f_abort    = 1'b0;
        q_push     = 1'b0;
        set_sstall = 1'b0;
        set_pdone  = 1'b0;
        unique case (st)
            RX_IDLE: if (tok_out) begin
                over_nxt = 1'b0;
                if (fstall) begin
                    hs_nxt     = HS_STALL;
                    set_sstall = 1'b1;
                    st_nxt     = RX_DROP_QUIET;
                end else if (free < PKT_F || q_full) begin
                    st_nxt = RX_DROP_NAK;
                end else begin
                    st_nxt = RX_RECV;
                end
            end
            RX_RECV: if (rx_eop) begin
                st_nxt = RX_IDLE;
                if (over) begin
                    hs_nxt  = HS_NAK;
                    f_abort = 1'b1;
                end else begin
                    hs_nxt    = HS_ACK;
                    f_commit  = 1'b1;
                    set_pdone = 1'b1;
                    q_push    = (cnt != '0);
                end
            end else if (rx_valid) begin
                if (cnt == PKT_C) over_nxt = 1'b1;
                else f_wr = 1'b1;
            end
            RX_DROP_NAK: if (rx_eop) begin
                hs_nxt = HS_NAK;
                st_nxt = RX_IDLE;
            end
            RX_DROP_QUIET: if (rx_eop) st_nxt = RX_IDLE;
            default: st_nxt = RX_IDLE;
        endcase
    end

    // Packet-side state, byte count and registered handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            cnt      <= '0;
            over     <= 1'b0;
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            st       <= st_nxt;
            over     <= over_nxt;
            hs_valid <= (hs_nxt != HS_NONE);
            hs_code  <= hs_nxt;
            if (rx_idle) cnt <= '0;
            else if (f_wr) cnt <= cnt + 1'b1;
        end
    end

    // Read side: count bytes of the head packet, retire it on its last byte
    assign pop_ok = fifo_rd && (level != '0);
    assign q_pop  = pop_ok && (CW'(rd_cnt + 1'b1) == head_len);

    always_ff @(posedge clk) begin
        if (!rst_n) rd_cnt <= '0;
        else if (q_pop) rd_cnt <= '0;
        else if (pop_ok) rd_cnt <= rd_cnt + 1'b1;
    end

    // Interrupt: packet complete, gated by low fill level in DMA mode
    assign irq = pdone && (!dma_mode || level < LOW_F);
endmodule

// File: rtl/usb_bulk_out_rx_chk.sv
// Temporal checks on the endpoint controller, attached with bind.
module usb_bulk_out_rx_chk #(
    parameter int LVW = 8,
    parameter int DEPTH = 128,
    parameter int LOW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tok_out,
    input logic           rx_idle,
    input logic           hs_valid,
    input logic [1:0]     hs_code,
    input logic [31:0]    reg_rdata,
    input logic           irq,
    input logic [LVW-1:0] level
);
    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:8] == '0) && !reg_rdata[2]);

    // R5
    stall_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && rx_idle && reg_rdata[5]) |=> (hs_valid && hs_code == 2'b11));

    // R6
    sstall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b11) |-> reg_rdata[4]);

    // R3
    svc_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |-> reg_rdata[6]);

    // R4
    short_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7] |-> reg_rdata[0]);

    // R7
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_rdata[1]);

    // R7
    irq_dma_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_rdata[3]) |-> (level < LVW'(LOW)));

    // R2
    hs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVW'(DEPTH));
endmodule

bind usb_bulk_out_rx usb_bulk_out_rx_chk #(
    .LVW($clog2(FIFO_DEPTH) + 1), .DEPTH(FIFO_DEPTH), .LOW(DMA_LOW_MARK)
) i_chk (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_idle(rx_idle),
    .hs_valid(hs_valid), .hs_code(hs_code), .reg_rdata(reg_rdata),
    .irq(irq), .level(level)
);

// File: tb/test_usb_bulk_out_rx.sv
// Scoreboard bench: driver tasks push expected handshakes and bytes into
// queues, a monitor compares handshakes as they appear.
module test_usb_bulk_out_rx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_out = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fifo_rd = 1'b0;
    logic [7:0]  fifo_rdata;
    logic        irq;

    int n_cmp = 0, n_bad = 0;

    // Reference model state
    logic [1:0] hs_exp[$];
    logic [7:0] byte_exp[$];
    int         m_len[$];
    int         m_head_rd = 0, m_level = 0;
    logic       m_fst = 0, m_sst = 0, m_dme = 0, m_rpc = 0;

    usb_bulk_out_rx i_usb_bulk_out_rx (
        .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_eop(rx_eop), .hs_valid(hs_valid),
        .hs_code(hs_code), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
        .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_reg();
        logic [31:0] r = '0;
        r[7] = (m_len.size() != 0) && (m_len[0] < 64);
        r[6] = m_level != 0;
        r[5] = m_fst;
        r[4] = m_sst;
        r[3] = m_dme;
        r[1] = m_rpc;
        r[0] = m_len.size() != 0;
        return r;
    endfunction

    // Compare status word and interrupt against the model (R3 R4 R7)
    task automatic check_state(input string tag);
        @(negedge clk);
        chk({tag, " R3/R4 status"}, reg_rdata, exp_reg());
        chk({tag, " R7 irq"}, {31'b0, irq},
            {31'b0, m_rpc && (!m_dme || m_level < 32)});
    endtask

    // Monitor: every handshake must match the next expected one (R2 R5 R8)
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            if (hs_exp.size() == 0) chk("R2 unexpected handshake", {30'b0, hs_code}, 32'hx);
            else chk("R2/R5/R8 handshake", {30'b0, hs_code}, {30'b0, hs_exp.pop_front()});
        end
    end

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        m_fst = v[5]; m_dme = v[3];
        if (v[4]) m_sst = 1'b0;
        if (v[1]) m_rpc = 1'b0;
    endtask

    // Driver: send one packet, predict its handshake and stored bytes
    task automatic send_pkt(input int len, input logic [7:0] base, input logic clr_at_eop);
        logic [1:0] hs;
        logic store = 1'b0;
        if (m_fst) hs = 2'b11;
        else if ((128 - m_level) < 64 || m_len.size() == 4 || len > 64) hs = 2'b10;
        else begin hs = 2'b01; store = 1'b1; end
        @(negedge clk);
        tok_out = 1'b1;
        if (hs == 2'b11) begin hs_exp.push_back(hs); m_sst = 1'b1; end
        @(negedge clk);
        tok_out = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_byte = base + 8'(i);
            if (store) byte_exp.push_back(base + 8'(i));
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_eop = 1'b1;
        if (clr_at_eop) begin reg_wr = 1'b1; reg_wdata = {26'b0, m_fst, 1'b0, m_dme, 3'b010}; end
        if (hs != 2'b11) hs_exp.push_back(hs);
        if (store) begin
            m_rpc = 1'b1;
            m_level += len;
            if (len > 0) m_len.push_back(len);
        end
        @(negedge clk);
        rx_eop = 1'b0; reg_wr = 1'b0;
    endtask

    // Pop n bytes and compare each against the scoreboard (R2 R10)
    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R2 byte order", {24'b0, fifo_rdata}, {24'b0, byte_exp.pop_front()});
            fifo_rd = 1'b1;
            m_level--; m_head_rd++;
            if (m_head_rd == m_len[0]) begin void'(m_len.pop_front()); m_head_rd = 0; end
        end
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 reset word", reg_rdata, 32'h0);
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset hs", {31'b0, hs_valid}, 32'h0);
        // R9: reserved bits ignore writes, controls read back
        wr_reg(32'hFFFF_FFFF);
        check_state("R9 all-ones write");
        wr_reg(32'h0);
        check_state("R9 zero write");
        // R2 R4: short packet then full packet
        send_pkt(10, 8'h10, 1'b0);
        check_state("R2 short pkt");
        send_pkt(64, 8'h40, 1'b0);
        check_state("R4 full pkt behind short");
        // R8: not enough free space
        send_pkt(5, 8'hA0, 1'b0);
        check_state("R8 no space");
        // R7: DMA mode with high fill gates irq
        wr_reg(32'h08);
        check_state("R7 dma high fill");
        // R10: drain first packet, flags advance to 64-byte packet
        drain(10);
        check_state("R10 advance");
        drain(40);
        check_state("R7 dma low fill");
        drain(24);
        check_state("R3 empty");
        // R10: pop while empty changes nothing
        @(negedge clk); fifo_rd = 1'b1;
        @(negedge clk); fifo_rd = 1'b0;
        check_state("R10 empty pop");
        // R6: clear packet complete
        wr_reg(32'h0A);
        check_state("R6 clear pdone");
        // R5: forced stall
        wr_reg(32'h20);
        send_pkt(5, 8'h55, 1'b0);
        check_state("R5 stall");
        wr_reg(32'h30);
        check_state("R6 clear sstall");
        wr_reg(32'h00);
        // R6: set wins over same-cycle clear
        send_pkt(3, 8'h70, 1'b1);
        check_state("R6 set beats clear");
        drain(3);
        wr_reg(32'h02);
        // R8: over-length packet
        send_pkt(65, 8'h80, 1'b0);
        check_state("R8 overlength");
        // R11: zero-length packet
        send_pkt(0, 8'h00, 1'b0);
        check_state("R11 zero length");
        // R8: length queue full
        for (int k = 0; k < 4; k++) send_pkt(1, 8'(8'hC0 + k), 1'b0);
        check_state("R8 queue filled");
        send_pkt(2, 8'hD0, 1'b0);
        check_state("R8 queue full");
        drain(4);
        check_state("R10 final drain");
        repeat (3) @(negedge clk);
        chk("R2 pending handshakes", hs_exp.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule